// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the register interface of one eight-line interrupt controller. Software reaches it through two byte-wide ports: a command port and a data port. Through the command port software starts the initialization sequence and issues operation commands. These commands cover the end-of-interrupt forms, setting and rotating priority, choosing which register a command read returns, special mask mode and poll. The data port carries the remaining initialization words and, once initialization is done, the interrupt mask.

The block holds the mask, the vector base, the cascade wiring byte, the lowest-priority index and the mode flags, and it exports all of them to the arbiter. It does not perform the priority scan over pending requests. It sends the arbiter three kinds of one-cycle pulse: a clear of one in-service bit (with its index), a rotate notice, and a flush that wipes the request and in-service registers when a valid initialization word arrives. It reads back the arbiter's request and in-service bytes for command-port reads. The parameter `IS_SECONDARY` makes the instance a cascaded secondary, which applies a stricter check to the wiring word.

Top module: `intc_prog_port`

## Requirements
- R1: After reset the mask is 0x00, the lowest-priority index is 0, init mode is off, the auto-EOI, rotate-in-auto-EOI, special-mask and poll flags are clear, command reads return the request byte, and read data is 0x00.
- R2: A command write with bit 4 set is an initialization word. It is accepted only when bit 0 is 1 and bits 7..5 and 3..1 are all 0. An accepted word clears the mask, sets the lowest-priority index to 7, clears rotate-in-auto-EOI, pulses flush for one cycle and enters init mode expecting word 2. A rejected word changes nothing.
- R3: In init mode, data writes are taken in order. Word 2 loads the vector base and word 3 loads the cascade byte, and neither touches the mask. A secondary rejects word 3 when any of bits 7..3 is set. A rejected word does not advance the sequence, so it can be written again.
- R4: Word 4 is rejected when bit 0 is 0 or any of bits 2, 3 or 7..5 is 1. An accepted word 4 copies bit 1 into the auto-EOI flag and leaves init mode.
- R5: Outside init mode a data write loads the mask. A data read returns the mask on rdata_o in the cycle after re_i is sampled.
- R6: A command write with bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects the register for command reads: bit 0 = 1 selects in-service, bit 0 = 0 selects request. With bit 1 = 0 the selection is kept. Command reads return the selected arbiter byte one cycle after re_i is sampled.
- R7: Commands 0x60..0x67 pulse clear-in-service with index = bits 2..0 and do not rotate.
- R8: Command 0x20 pulses clear-in-service for the set in-service bit of highest priority. Priority starts at lowest-priority index + 1 and rises modulo 8. No pulse occurs when no in-service bit is set.
- R9: Command 0xA0 behaves like 0x20, and 0xE0..0xE7 behave like 0x60..0x67. Both also pulse rotate and increment the lowest-priority index modulo 8.
- R10: Commands 0xC0..0xC7 load the lowest-priority index from bits 2..0. 0x80 sets and 0x00 clears the rotate-in-auto-EOI flag. 0x40, and EOI-bit codes outside the four forms (such as 0x21), have no effect.
- R11: A command with bit 4 = 0, bit 3 = 1 and bit 6 = 1 sets the special-mask flag to bit 5. With bit 6 = 0 the flag is kept. Bit 2 = 1 sets the poll flag.
- R12: The clear-in-service, rotate and flush pulses and all register updates appear in the cycle right after the write is sampled, and the pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects the command port, 1 the data port |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| arb_irr_i | input | 8 | Request byte from the arbiter |
| arb_isr_i | input | 8 | In-service byte from the arbiter |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base |
| cascade_o | output | 8 | Cascade wiring byte |
| lowest_pri_o | output | 3 | Lowest-priority index |
| auto_eoi_o | output | 1 | Auto-EOI flag |
| rot_aeoi_o | output | 1 | Rotate-in-auto-EOI flag |
| smm_o | output | 1 | Special-mask flag |
| poll_o | output | 1 | Poll flag |
| init_active_o | output | 1 | Initialization sequence in progress |
| clr_isr_o | output | 1 | Clear-in-service pulse |
| clr_isr_idx_o | output | 3 | Index of the bit to clear |
| rotate_o | output | 1 | Rotate notice pulse |
| flush_o | output | 1 | Flush pulse for the request and in-service registers |

## Verification
Every write result arrives exactly one cycle after the write is sampled: the state registers, the clear-in-service, rotate and flush pulses, and the init-mode change. Read data also arrives one cycle after re_i is sampled, and it then holds until the next read. The bench drives each strobe on a falling edge and removes it on the next falling edge. It checks at that point, which is half a cycle after the one capturing edge. Each pulse is therefore caught in its only valid cycle, and a pulse that came a cycle late or lasted too long would show up as a mismatch at the following check.

// File: rtl/intc_prog_pkg.sv
package intc_prog_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LINES  = 8;
  localparam int unsigned IDX_W  = $clog2(LINES);

  typedef enum logic [1:0] {
    EOI_NONE,
    EOI_SPEC,
    EOI_NSPEC
  } eoi_e;

  typedef struct packed {
    logic init_hit;
    logic init_ok;
    logic ocw3;
    eoi_e eoi;
    logic eoi_rot;
    logic set_pri;
    logic raeoi_set;
    logic raeoi_clr;
    logic sel_upd;
    logic sel_isr;
    logic smm_upd;
    logic smm_val;
    logic poll;
  } cmd_t;
endpackage

// File: rtl/intc_cmd_decode.sv
module intc_cmd_decode
  import intc_prog_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output cmd_t              cmd_o
);
  always_comb begin
    cmd_o     = '0;
    cmd_o.eoi = EOI_NONE;
    if (byte_i[4]) begin
      cmd_o.init_hit = 1'b1;
      cmd_o.init_ok  = byte_i[0] && (byte_i[3:1] == 3'b000) && (byte_i[7:5] == 3'b000);
    end else if (byte_i[3]) begin
      cmd_o.ocw3    = 1'b1;
      cmd_o.sel_upd = byte_i[1];
      cmd_o.sel_isr = byte_i[0];
      cmd_o.smm_upd = byte_i[6];
      cmd_o.smm_val = byte_i[5];
      cmd_o.poll    = byte_i[2];
    end else if (byte_i[5]) begin
      // bits 7:6 pick rotate / specific
      cmd_o.eoi_rot = byte_i[7];
      if (byte_i[6]) begin
        cmd_o.eoi = EOI_SPEC;
      end else if (byte_i[2:0] == 3'b000) begin
        cmd_o.eoi = EOI_NSPEC;
      end
    end else begin
      if (byte_i[7:6] == 2'b11) begin
        cmd_o.set_pri = 1'b1;
      end else if (byte_i[7:6] == 2'b10 && byte_i[2:0] == 3'b000) begin
        cmd_o.raeoi_set = 1'b1;
      end else if (byte_i[7:6] == 2'b00 && byte_i[2:0] == 3'b000) begin
        cmd_o.raeoi_clr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_isr_pick.sv
module intc_isr_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] low_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] pos [N];

  for (genvar k = 0; k < N; k++) begin : g_pos
    assign pos[k] = IDX_W'(low_i + IDX_W'(k + 1));
  end

  // smallest offset from the rotation point wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[pos[k]]) begin
        found_o = 1'b1;
        idx_o   = pos[k];
      end
    end
  end
endmodule

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_prog_pkg::*;
#(
  parameter bit IS_SECONDARY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              active_o,
  output logic [BYTE_W-1:0] vec_o,
  output logic [BYTE_W-1:0] casc_o,
  output logic              aeoi_o
);
  typedef enum logic [1:0] {ST_W2, ST_W3, ST_W4} step_e;

  step_e            step_q;
  logic             active_q;
  logic [BYTE_W-1:0] vec_q, casc_q;
  logic             aeoi_q;
  logic             w3_ok, w4_ok;

  assign w3_ok = !(IS_SECONDARY && (data_i[7:3] != 5'd0));
  assign w4_ok = data_i[0] && !data_i[2] && !data_i[3] && (data_i[7:5] == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= ST_W2;
      active_q <= 1'b0;
      vec_q    <= '0;
      casc_q   <= '0;
      aeoi_q   <= 1'b0;
    end else if (start_i) begin
      step_q   <= ST_W2;
      active_q <= 1'b1;
    end else if (wr_i && active_q) begin
      unique case (step_q)
        ST_W2: begin
          vec_q  <= data_i;
          step_q <= ST_W3;
        end
        ST_W3: if (w3_ok) begin
          casc_q <= data_i;
          step_q <= ST_W4;
        end
        ST_W4: if (w4_ok) begin
          aeoi_q   <= data_i[1];
          active_q <= 1'b0;
          step_q   <= ST_W2;
        end
        default: step_q <= ST_W2;
      endcase
    end
  end

  assign active_o = active_q;
  assign vec_o    = vec_q;
  assign casc_o   = casc_q;
  assign aeoi_o   = aeoi_q;
endmodule

// File: rtl/intc_prog_port.sv
module intc_prog_port
  import intc_prog_pkg::*;
#(
  parameter bit IS_SECONDARY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [LINES-1:0]  arb_irr_i,
  input  logic [LINES-1:0]  arb_isr_i,
  output logic [LINES-1:0]  mask_o,
  output logic [BYTE_W-1:0] vec_base_o,
  output logic [BYTE_W-1:0] cascade_o,
  output logic [IDX_W-1:0]  lowest_pri_o,
  output logic              auto_eoi_o,
  output logic              rot_aeoi_o,
  output logic              smm_o,
  output logic              poll_o,
  output logic              init_active_o,
  output logic              clr_isr_o,
  output logic [IDX_W-1:0]  clr_isr_idx_o,
  output logic              rotate_o,
  output logic              flush_o
);
  cmd_t              cmd;
  logic              wr_cmd, wr_dat;
  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic              init_active;

  logic [LINES-1:0]  mask_q;
  logic [IDX_W-1:0]  low_q;
  logic              raeoi_q, smm_q, poll_q, sel_isr_q;
  logic [BYTE_W-1:0] rdata_q;
  logic              clr_q, rot_q, flush_q;
  logic [IDX_W-1:0]  clr_idx_q;

  assign wr_cmd = we_i && !addr_i;
  assign wr_dat = we_i && addr_i;

  intc_cmd_decode u_dec (
    .byte_i (wdata_i),
    .cmd_o  (cmd)
  );

  intc_isr_pick #(.N(LINES), .IDX_W(IDX_W)) u_pick (
    .req_i   (arb_isr_i),
    .low_i   (low_q),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  intc_init_seq #(.IS_SECONDARY(IS_SECONDARY)) u_init (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wr_cmd && cmd.init_hit && cmd.init_ok),
    .wr_i     (wr_dat),
    .data_i   (wdata_i),
    .active_o (init_active),
    .vec_o    (vec_base_o),
    .casc_o   (cascade_o),
    .aeoi_o   (auto_eoi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '0;
      low_q     <= '0;
      raeoi_q   <= 1'b0;
      smm_q     <= 1'b0;
      poll_q    <= 1'b0;
      sel_isr_q <= 1'b0;
      clr_q     <= 1'b0;
      clr_idx_q <= '0;
      rot_q     <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      clr_q   <= 1'b0;
      rot_q   <= 1'b0;
      flush_q <= 1'b0;
      if (wr_cmd) begin
        if (cmd.init_hit) begin
          if (cmd.init_ok) begin
            mask_q  <= '0;
            low_q   <= IDX_W'(LINES - 1);
            raeoi_q <= 1'b0;
            flush_q <= 1'b1;
          end
        end else if (cmd.ocw3) begin
          if (cmd.sel_upd) sel_isr_q <= cmd.sel_isr;
          if (cmd.smm_upd) smm_q     <= cmd.smm_val;
          if (cmd.poll)    poll_q    <= 1'b1;
        end else begin
          unique case (cmd.eoi)
            EOI_SPEC: begin
              clr_q     <= 1'b1;
              clr_idx_q <= wdata_i[IDX_W-1:0];
            end
            EOI_NSPEC: begin
              clr_q     <= pick_found;
              clr_idx_q <= pick_idx;
            end
            default: ;
          endcase
          if (cmd.eoi != EOI_NONE && cmd.eoi_rot) begin
            low_q <= low_q + 1'b1;
            rot_q <= 1'b1;
          end
          if (cmd.set_pri)   low_q   <= wdata_i[IDX_W-1:0];
          if (cmd.raeoi_set) raeoi_q <= 1'b1;
          if (cmd.raeoi_clr) raeoi_q <= 1'b0;
        end
      end else if (wr_dat && !init_active) begin
        mask_q <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (re_i) begin
      if (addr_i)         rdata_q <= mask_q;
      else if (sel_isr_q) rdata_q <= arb_isr_i;
      else                rdata_q <= arb_irr_i;
    end
  end

  assign rdata_o       = rdata_q;
  assign mask_o        = mask_q;
  assign lowest_pri_o  = low_q;
  assign rot_aeoi_o    = raeoi_q;
  assign smm_o         = smm_q;
  assign poll_o        = poll_q;
  assign init_active_o = init_active;
  assign clr_isr_o     = clr_q;
  assign clr_isr_idx_o = clr_idx_q;
  assign rotate_o      = rot_q;
  assign flush_o       = flush_q;
endmodule

// File: rtl/intc_prog_port_chk.sv
module intc_prog_port_chk
  import intc_prog_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic [LINES-1:0]  mask_o,
  input logic [IDX_W-1:0]  lowest_pri_o,
  input logic              rot_aeoi_o,
  input logic              init_active_o,
  input logic              clr_isr_o,
  input logic              rotate_o,
  input logic              flush_o
);
  p_clr_after_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_isr_o |-> $past(we_i && !addr_i));

  p_rotate_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rotate_o |-> (lowest_pri_o == IDX_W'($past(lowest_pri_o) + 1'b1)));

  p_flush_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (mask_o == '0 && lowest_pri_o == IDX_W'(LINES - 1)
                 && init_active_o && !rot_aeoi_o));

  p_mask_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));

  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  p_init_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_active_o) |-> $past(we_i && addr_i));

  p_pulse_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
endmodule

bind intc_prog_port intc_prog_port_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .we_i          (we_i),
  .re_i          (re_i),
  .rdata_o       (rdata_o),
  .mask_o        (mask_o),
  .lowest_pri_o  (lowest_pri_o),
  .rot_aeoi_o    (rot_aeoi_o),
  .init_active_o (init_active_o),
  .clr_isr_o     (clr_isr_o),
  .rotate_o      (rotate_o),
  .flush_o       (flush_o)
);

// File: tb/tb_intc_prog_port.sv
module tb_intc_prog_port;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, we = 1'b0, we_s = 1'b0, re = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] irr = '0, isr = '0;

  logic [7:0] rdata, mask, vec, casc;
  logic [2:0] low, cidx;
  logic       aeoi, raeoi, smm, poll, iact, clr, rot, flush;

  logic [7:0] s_rdata, s_mask, s_vec, s_casc;
  logic [2:0] s_low, s_cidx;
  logic       s_aeoi, s_raeoi, s_smm, s_poll, s_iact, s_clr, s_rot, s_flush;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  intc_prog_port dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .arb_irr_i(irr), .arb_isr_i(isr),
    .mask_o(mask), .vec_base_o(vec), .cascade_o(casc), .lowest_pri_o(low),
    .auto_eoi_o(aeoi), .rot_aeoi_o(raeoi), .smm_o(smm), .poll_o(poll),
    .init_active_o(iact), .clr_isr_o(clr), .clr_isr_idx_o(cidx),
    .rotate_o(rot), .flush_o(flush)
  );

  intc_prog_port #(.IS_SECONDARY(1'b1)) dut_sec (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we_s), .re_i(1'b0),
    .wdata_i(wdata), .rdata_o(s_rdata), .arb_irr_i(irr), .arb_isr_i(isr),
    .mask_o(s_mask), .vec_base_o(s_vec), .cascade_o(s_casc), .lowest_pri_o(s_low),
    .auto_eoi_o(s_aeoi), .rot_aeoi_o(s_raeoi), .smm_o(s_smm), .poll_o(s_poll),
    .init_active_o(s_iact), .clr_isr_o(s_clr), .clr_isr_idx_o(s_cidx),
    .rotate_o(s_rot), .flush_o(s_flush)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one write, checked half a cycle after the capturing edge
  task automatic wr(input logic sec, input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (sec) we_s = 1'b1; else we = 1'b1;
    @(negedge clk);
    we = 1'b0; we_s = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    chk("R1 mask", mask, 8'h00);
    chk("R1 lowest", low, 3'd0);
    chk("R1 init", iact, 1'b0);
    chk("R1 flags", {aeoi, raeoi, smm, poll}, 4'b0000);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 pulses", {clr, rot, flush}, 3'b000);
  endtask

  task automatic t_init;
    wr(0, 0, 8'h80);
    wr(0, 1, 8'h55);
    chk("R10 raeoi set", raeoi, 1'b1);
    wr(0, 0, 8'h13);
    chk("R2 reject single", {iact, flush}, 2'b00);
    chk("R2 reject keeps mask", mask, 8'h55);
    wr(0, 0, 8'h19);
    chk("R2 reject level", iact, 1'b0);
    wr(0, 0, 8'h11);
    chk("R2 flush pulse", flush, 1'b1);
    chk("R2 accept state", {mask, 5'd0, low, 7'd0, raeoi, 7'd0, iact}, {8'h00, 5'd0, 3'd7, 8'h00, 8'h01});
    @(negedge clk);
    chk("R12 flush one cycle", flush, 1'b0);
    wr(0, 1, 8'hA8);
    chk("R3 vector", vec, 8'hA8);
    chk("R3 mask untouched", mask, 8'h00);
    wr(0, 1, 8'hF4);
    chk("R3 cascade primary", casc, 8'hF4);
    wr(0, 1, 8'h00);
    chk("R4 reject cpu bit", iact, 1'b1);
    wr(0, 1, 8'h09);
    chk("R4 reject buffered", iact, 1'b1);
    wr(0, 1, 8'h21);
    chk("R4 reject high bits", iact, 1'b1);
    wr(0, 1, 8'h03);
    chk("R4 accept", {iact, aeoi}, 2'b01);
    // secondary instance
    wr(1, 0, 8'h11);
    wr(1, 1, 8'h70);
    wr(1, 1, 8'h0A);
    chk("R3 secondary reject", {s_iact, s_casc}, {1'b1, 8'h00});
    wr(1, 1, 8'h02);
    chk("R3 secondary accept", s_casc, 8'h02);
    wr(1, 1, 8'h01);
    chk("R4 secondary done", {s_iact, s_aeoi, s_vec}, {2'b00, 8'h70});
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(0, 1, 8'h5A);
    chk("R5 mask load", mask, 8'h5A);
    rd(1, d);
    chk("R5 mask read", d, 8'h5A);
  endtask

  task automatic t_readsel;
    logic [7:0] d;
    irr = 8'h33; isr = 8'hC4;
    rd(0, d);
    chk("R6 default request", d, 8'h33);
    wr(0, 0, 8'h0B);
    rd(0, d);
    chk("R6 select in-service", d, 8'hC4);
    wr(0, 0, 8'h08);
    rd(0, d);
    chk("R6 selection kept", d, 8'hC4);
    wr(0, 0, 8'h0A);
    rd(0, d);
    chk("R6 select request", d, 8'h33);
  endtask

  task automatic t_seoi;
    wr(0, 0, 8'h65);
    chk("R7 specific clear", {clr, 5'd0, cidx}, {1'b1, 5'd0, 3'd5});
    chk("R7 no rotate", {rot, 4'd0, low}, {1'b0, 4'd0, 3'd7});
    @(negedge clk);
    chk("R12 clear one cycle", clr, 1'b0);
  endtask

  task automatic t_nseoi;
    isr = 8'hC4;
    wr(0, 0, 8'h20);
    chk("R8 pick from 0", {clr, 5'd0, cidx}, {1'b1, 5'd0, 3'd2});
    wr(0, 0, 8'hC2);
    chk("R10 set priority", low, 3'd2);
    wr(0, 0, 8'h20);
    chk("R8 pick from 3", {clr, 5'd0, cidx}, {1'b1, 5'd0, 3'd6});
    isr = 8'h00;
    wr(0, 0, 8'h20);
    chk("R8 none in service", clr, 1'b0);
  endtask

  task automatic t_rot;
    isr = 8'hC4;
    wr(0, 0, 8'hA0);
    chk("R9 nonspecific rotate", {clr, rot, 3'd0, cidx}, {2'b11, 3'd0, 3'd6});
    chk("R9 lowest after", low, 3'd3);
    wr(0, 0, 8'hE1);
    chk("R9 specific rotate", {clr, rot, 3'd0, cidx, 5'd0, low}, {2'b11, 3'd0, 3'd1, 5'd0, 3'd4});
    wr(0, 0, 8'hC7);
    wr(0, 0, 8'hE0);
    chk("R9 wrap", low, 3'd0);
  endtask

  task automatic t_misc;
    wr(0, 0, 8'h80);
    chk("R10 raeoi on", raeoi, 1'b1);
    wr(0, 0, 8'h40);
    chk("R10 nop", {clr, rot, raeoi, 5'd0, low, mask}, {3'b001, 5'd0, 3'd0, 8'h5A});
    wr(0, 0, 8'h21);
    chk("R10 odd eoi ignored", {clr, rot, 3'd0, low}, {2'b00, 3'd0, 3'd0});
    wr(0, 0, 8'h00);
    chk("R10 raeoi off", raeoi, 1'b0);
  endtask

  task automatic t_ocw3;
    wr(0, 0, 8'h68);
    chk("R11 smm set", smm, 1'b1);
    wr(0, 0, 8'h28);
    chk("R11 smm kept", smm, 1'b1);
    wr(0, 0, 8'h48);
    chk("R11 smm clear", smm, 1'b0);
    chk("R11 poll idle", poll, 1'b0);
    wr(0, 0, 8'h0C);
    chk("R11 poll set", poll, 1'b1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_init;
    t_mask;
    t_readsel;
    t_seoi;
    t_nseoi;
    t_rot;
    t_misc;
    t_ocw3;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule